// File: doc/BRIEF.md
# Window Comparator Interrupt Unit

This block watches the results of a multi-channel converter and tells a host when a channel leaves a programmed window. Each time a channel stores a new result, the block takes the eight most significant bits of that result and compares them with the channel's own upper and lower limit. A value above the upper limit sets the channel's high flag, and a value below the lower limit sets its low flag. Flags stay set until the host reads the flag register. That read clears every flag.

The limits arrive as byte writes from a serial host interface. Each channel takes two bytes in turn: the upper limit first, then the lower limit. The block drives a shared active-low open-drain interrupt line, shown here as a single output enable that pulls the line low. The line is pulled while at least one set flag belongs to a limit that is not zero. A limit of zero still lets its flag be set, but that flag can never raise the interrupt.

Top module: `win_cmp_irq`

## Requirements
- R1: The compared value of channel c is bits [c*10+9 : c*10+2] of `resultData`; the two low bits of each result have no effect. A high flag is set only when this value is strictly greater than the upper limit, so an equal value sets nothing.
- R2: The low flag of a channel is set only when the compared value is strictly less than the lower limit. With a lower limit of zero the low flag can never be set.
- R3: Flag bit 2c+1 is the high flag and bit 2c is the low flag of channel c (c = 0..3). Several channels that are evaluated in the same cycle set their flags together.
- R4: A comparison happens only in a cycle where `resultValid[c]` is 1. Result data that changes while the strobe is low has no effect. Set flags stay set until a read clears them.
- R5: A cycle with `flagRead` high clears all flags at the next clock edge. A flag condition evaluated in that same cycle is still set afterwards.
- R6: Limit writes to a channel alternate: the first byte is the upper limit and the second is the lower limit, and this pattern repeats. Each channel keeps its own place in the sequence.
- R7: After reset all limits, all flags and the place in each write sequence are zero, and `irqOe` is 0. A result above zero still sets a high flag, but the interrupt stays off.
- R8: `irqOe` is 1 exactly when some set flag has a nonzero limit belonging to it: the upper limit for a high flag, the lower limit for a low flag.
- R9: Flags and `irqOe` reflect a strobe, a read or a limit write from the clock edge that ends that cycle. A comparison in the same cycle as a limit write uses the limit value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| resultData | input | 40 | Four 10-bit results, channel c at bits [c*10+9 : c*10] |
| resultValid | input | 4 | Per-channel strobe: a new result is stored this cycle |
| refWrEn | input | 1 | Limit byte write strobe |
| refWrCh | input | 2 | Channel addressed by the limit write |
| refWrByte | input | 8 | Limit byte |
| flagRead | input | 1 | Flag register read strobe; clears flags afterwards |
| flagData | output | 8 | Flag register, high and low flags interleaved per channel |
| irqOe | output | 1 | Interrupt output enable; 1 pulls the shared line low |

## Verification
The stimulus places each compared value at its limit, one step above it and one step below it. This separates strict comparisons from inclusive ones and shows that the two low result bits are ignored. Values that exceed a zero upper limit set a flag while the interrupt stays off, which distinguishes setting a flag from the interrupt mask. A read that falls in the same cycle as a new condition shows whether the clear or the set wins. A strobe-low cycle with changed data shows whether the comparison is gated by the strobe. A limit that is rewritten as zero, followed by a lower-limit crossing, checks that the byte order of the writes alternates per channel. Finally, several channels are strobed in one cycle to check the bit positions of the flag layout.

// File: rtl/win_cmp_pkg.sv
package win_cmp_pkg;
  localparam int WC_NUM_CH = 4;
  localparam int WC_RES_W  = 10;
  localparam int WC_CMP_W  = 8;
  localparam int WC_FLAG_W = 2 * WC_NUM_CH;

  typedef struct packed {
    logic [WC_NUM_CH-1:0] loadUpper;
    logic [WC_NUM_CH-1:0] loadLower;
    logic [WC_NUM_CH-1:0] evalCh;
    logic                 clearAll;
  } winCtl_t;
endpackage

// File: rtl/win_cmp_ctrl.sv
module win_cmp_ctrl
  import win_cmp_pkg::*;
#(
  parameter int NUM_CH = WC_NUM_CH,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] resultValid,
  input  logic              refWrEn,
  input  logic [CH_W-1:0]   refWrCh,
  input  logic              flagRead,
  output winCtl_t           ctl
);
  logic [NUM_CH-1:0] lowerNext;

  always_comb begin
    ctl.loadUpper = '0;
    ctl.loadLower = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (refWrEn && (refWrCh == CH_W'(c))) begin
        ctl.loadUpper[c] = !lowerNext[c];
        ctl.loadLower[c] = lowerNext[c];
      end
    end
    ctl.evalCh   = resultValid;
    ctl.clearAll = flagRead;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowerNext <= '0;
    else lowerNext <= lowerNext ^ (ctl.loadUpper | ctl.loadLower);
  end

  // R6
  one_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.loadUpper, ctl.loadLower}));

  // R6
  phase_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refWrEn && !lowerNext[refWrCh]) |=> lowerNext[$past(refWrCh)]);
endmodule

// File: rtl/win_cmp_datapath.sv
module win_cmp_datapath
  import win_cmp_pkg::*;
#(
  parameter int NUM_CH = WC_NUM_CH,
  parameter int RES_W  = WC_RES_W,
  parameter int CMP_W  = WC_CMP_W,
  localparam int FLAG_W = 2 * NUM_CH
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  winCtl_t                 ctl,
  input  logic [NUM_CH*RES_W-1:0] resultData,
  input  logic [CMP_W-1:0]        refByte,
  output logic [FLAG_W-1:0]       flags,
  output logic                    irqOe
);
  logic [CMP_W-1:0]  upperRef [NUM_CH];
  logic [CMP_W-1:0]  lowerRef [NUM_CH];
  logic [FLAG_W-1:0] newSet;
  logic [FLAG_W-1:0] armMask;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CMP_W-1:0] topBits;
    assign topBits = resultData[c*RES_W + RES_W-1 -: CMP_W];
    assign newSet[2*c+1] = ctl.evalCh[c] && (topBits > upperRef[c]);
    assign newSet[2*c]   = ctl.evalCh[c] && (topBits < lowerRef[c]);
    assign armMask[2*c+1] = (upperRef[c] != '0);
    assign armMask[2*c]   = (lowerRef[c] != '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        upperRef[c] <= '0;
        lowerRef[c] <= '0;
      end else begin
        if (ctl.loadUpper[c]) upperRef[c] <= refByte;
        if (ctl.loadLower[c]) lowerRef[c] <= refByte;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else flags <= (ctl.clearAll ? '0 : flags) | newSet;
  end

  assign irqOe = |(flags & armMask);

  // R5
  read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.clearAll && ctl.evalCh == '0) |=> flags == '0);

  // R4
  sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.clearAll |=> ((flags & $past(flags)) == $past(flags)));

  // R4
  no_eval_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.evalCh == '0) |=> ((flags & ~$past(flags)) == '0));

  // R8
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOe |-> (flags != '0));
endmodule

// File: rtl/win_cmp_irq.sv
module win_cmp_irq
  import win_cmp_pkg::*;
#(
  parameter int NUM_CH = WC_NUM_CH,
  parameter int RES_W  = WC_RES_W,
  parameter int CMP_W  = WC_CMP_W,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int FLAG_W = 2 * NUM_CH
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CH*RES_W-1:0] resultData,
  input  logic [NUM_CH-1:0]       resultValid,
  input  logic                    refWrEn,
  input  logic [CH_W-1:0]         refWrCh,
  input  logic [CMP_W-1:0]        refWrByte,
  input  logic                    flagRead,
  output logic [FLAG_W-1:0]       flagData,
  output logic                    irqOe
);
  winCtl_t ctl;

  win_cmp_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rstN(rstN), .resultValid(resultValid),
    .refWrEn(refWrEn), .refWrCh(refWrCh), .flagRead(flagRead), .ctl(ctl));

  win_cmp_datapath #(.NUM_CH(NUM_CH), .RES_W(RES_W), .CMP_W(CMP_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .resultData(resultData),
    .refByte(refWrByte), .flags(flagData), .irqOe(irqOe));
endmodule

// File: tb/win_cmp_irq_tb.sv
`timescale 1ns/1ps
module win_cmp_irq_tb;
  logic        clk = 0;
  logic        rstN = 0;
  logic [39:0] resultData = '0;
  logic [3:0]  resultValid = '0;
  logic        refWrEn = 0;
  logic [1:0]  refWrCh = '0;
  logic [7:0]  refWrByte = '0;
  logic        flagRead = 0;
  logic [7:0]  flagData;
  logic        irqOe;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  logic [7:0] mUp [4];
  logic [7:0] mLo [4];
  logic [3:0] mPh;
  logic [7:0] mFlags;

  logic [7:0] expFlagsQ [$];
  logic       expIrqQ [$];
  string      tagQ [$];

  always #4 clk = ~clk;

  win_cmp_irq u_dut (
    .clk(clk), .rstN(rstN), .resultData(resultData), .resultValid(resultValid),
    .refWrEn(refWrEn), .refWrCh(refWrCh), .refWrByte(refWrByte),
    .flagRead(flagRead), .flagData(flagData), .irqOe(irqOe));

  function automatic logic modelIrq();
    logic r = 0;
    for (int c = 0; c < 4; c++) begin
      if (mFlags[2*c+1] && mUp[c] != 0) r = 1;
      if (mFlags[2*c] && mLo[c] != 0) r = 1;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [7:0] fAct, fExp, input logic iAct, iExp);
    nChecks++;
    if (fAct !== fExp || iAct !== iExp) begin
      nFails++;
      $display("FAIL %s: flags=%h irq=%b expected flags=%h irq=%b", tag, fAct, iAct, fExp, iExp);
    end
  endtask

  task automatic step(input logic [3:0] vMask, input logic [7:0] t0, t1, t2, t3,
                      input logic rd, input logic we, input logic [1:0] wch,
                      input logic [7:0] wb, input string tag);
    logic [7:0] tv [4];
    logic [7:0] sets;
    tv[0] = t0; tv[1] = t1; tv[2] = t2; tv[3] = t3;
    #1;
    for (int c = 0; c < 4; c++)
      resultData[c*10 +: 10] = {tv[c], 2'(c + 1)};
    resultValid = vMask;
    flagRead = rd;
    refWrEn = we;
    refWrCh = wch;
    refWrByte = wb;
    sets = '0;
    for (int c = 0; c < 4; c++) begin
      if (vMask[c] && tv[c] > mUp[c]) sets[2*c+1] = 1;
      if (vMask[c] && tv[c] < mLo[c]) sets[2*c] = 1;
    end
    mFlags = (rd ? 8'h00 : mFlags) | sets;
    if (we) begin
      if (mPh[wch]) mLo[wch] = wb;
      else mUp[wch] = wb;
      mPh[wch] = ~mPh[wch];
    end
    @(posedge clk);
    expFlagsQ.push_back(mFlags);
    expIrqQ.push_back(modelIrq());
    tagQ.push_back(tag);
  endtask

  task automatic wr(input logic [1:0] ch, input logic [7:0] b, input string tag);
    step(4'h0, 8'h00, 8'h00, 8'h00, 8'h00, 0, 1, ch, b, tag);
  endtask

  always @(negedge clk) begin
    if (expFlagsQ.size() > 0)
      check(tagQ.pop_front(), flagData, expFlagsQ.pop_front(), irqOe, expIrqQ.pop_front());
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: flags=%h irq=%b expected completion", flagData, irqOe);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) begin mUp[c] = 0; mLo[c] = 0; end
    mPh = 0;
    mFlags = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 reset state", flagData, 8'h00, irqOe, 1'b0);
    rstN = 1;
    @(posedge clk);
    // R7: zero limits, flag set but interrupt off
    step(4'h1, 8'h05, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0, "R7 zero upper masks irq");
    step(4'h0, 8'h00, 8'h00, 8'h00, 8'h00, 1, 0, 0, 0, "R5 read clears");
    // R6: limits, upper then lower per channel
    wr(0, 8'h80, "R6 ch0 upper");
    wr(1, 8'h40, "R6 ch1 upper");
    wr(0, 8'h20, "R6 ch0 lower");
    wr(1, 8'h10, "R6 ch1 lower");
    wr(2, 8'hF0, "R6 ch2 upper");
    wr(2, 8'h00, "R6 ch2 lower");
    wr(3, 8'h00, "R6 ch3 upper");
    wr(3, 8'h30, "R6 ch3 lower");
    step(4'h1, 8'h80, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0, "R1 equal sets nothing");
    step(4'h1, 8'h81, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0, "R1 above upper, R8 irq");
    step(4'h0, 8'h00, 8'h00, 8'h00, 8'h00, 1, 0, 0, 0, "R5 read clears irq");
    step(4'h2, 8'h00, 8'h0F, 8'h00, 8'h00, 0, 0, 0, 0, "R2 below lower bit2 R3");
    step(4'h0, 8'hFF, 8'h00, 8'hFF, 8'h00, 0, 0, 0, 0, "R4 no strobe no effect");
    step(4'h2, 8'h00, 8'h10, 8'h00, 8'h00, 0, 0, 0, 0, "R2 equal lower sets nothing");
    step(4'h8, 8'h00, 8'h00, 8'h00, 8'h10, 1, 0, 0, 0, "R5 set survives read");
    step(4'h0, 8'h00, 8'h00, 8'h00, 8'h00, 1, 0, 0, 0, "R5 read clears");
    step(4'h8, 8'h00, 8'h00, 8'h00, 8'hFF, 0, 0, 0, 0, "R8 zero upper no irq");
    step(4'h4, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0, "R2 zero lower never low");
    step(4'h4, 8'h00, 8'h00, 8'hF1, 8'h00, 0, 0, 0, 0, "R8 ch2 high irq");
    step(4'h0, 8'h00, 8'h00, 8'h00, 8'h00, 1, 0, 0, 0, "R5 read clears");
    step(4'hF, 8'h81, 8'h05, 8'hF8, 8'h2F, 0, 0, 0, 0, "R3 all channels together");
    step(4'h0, 8'h00, 8'h00, 8'h00, 8'h00, 1, 0, 0, 0, "R5 read clears");
    // R9: compare uses old limit during write
    step(4'h1, 8'h70, 8'h00, 8'h00, 8'h00, 0, 1, 0, 8'h00, "R9 old limit used");
    wr(0, 8'h20, "R6 ch0 lower rewrite");
    step(4'h1, 8'h90, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0, "R8 rewritten zero upper");
    step(4'h1, 8'h10, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0, "R6 second byte went to lower");
    #1;
    resultValid = 0; flagRead = 0; refWrEn = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    #1;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule